// File: doc/BRIEF.md
# Register-Commanded SPI Word Engine

This block is an SPI master driven through a small 32-bit register bus. Software picks the serial clock rate and the per-device signalling mode, loads up to 128 bits into four data registers, and then writes one command. Each accepted command shifts exactly one word of 1 to 128 bits across the serial pins, most significant bit first. It then reports completion in a status register. Software polls the status register, reads any received word from the data registers, and issues the next command.

A frame can span many word commands. The selected device line stays asserted from the first word until software issues an explicit end-of-frame command. Clock polarity, clock phase and select polarity are held per device in 8-bit lanes of one control register, so one engine can serve up to four devices with different modes. An optional three-wire mode reads from the shared bidirectional data line and releases the output driver for the duration of a read word.

Register word addresses: 0 clock control, 1 device control, 2 command, 3 status, 4 to 7 data (4 holds bits 31:0, 5 bits 63:32, 6 bits 95:64, 7 bits 127:96).

Top module: `spi_word_engine`

## Requirements
- R1: Clock control (address 0) holds the enable at bit 31 and the divider in bits 15:0. One SCLK period lasts (D+1) clock cycles, where D is the divider, and a divider of 0 acts as 1. While the enable is 0, SCLK rests at the idle level of the selected lane and a pending word does not advance.
- R2: Device control (address 1) gives device i the lane at bits 8i+7:8i. Lane bit 0 is the SCLK idle level. Lane bit 1 is the select active level, where 0 means active low. Lane bit 2 is the phase. With phase 0, the first bit is on the data line before the leading edge, and both sides sample on the leading edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R3: The command (address 2) carries the device number in bits 29:28, the word length minus one in bits 25:19, and a frame length in bits 11:0. The operation code is in bits 18:16: 1 reads a word, 2 writes a word, 5 and 6 are the same operations in three-wire mode (bit 18 set), and 4 ends the frame. An accepted command reads back unchanged from address 2.
- R4: An accepted read or write word drives only the chosen select line to its active level. The line stays active after the word ends and through later words. It returns to inactive only on code 4. At most one select line is active at any time.
- R5: Status (address 3) has word-complete at bit 1 and busy at bit 0. The cycle after a read or write command is accepted, status reads busy=1 and complete=0. When the last bit is shifted, it reads busy=0 and complete=1. Any accepted command, including code 4, clears complete.
- R6: A command write arriving while busy is ignored. The word in flight keeps its length and device, and the command register keeps its value.
- R7: A write word sends the low L bits of the data registers MSB first, where L is the word length. The data registers are left unchanged.
- R8: A read word receives L bits MSB first and places them in the low L bits of the data registers, with all higher bits zero.
- R9: During a three-wire read word, the output enable is low and received bits come from the bidirectional line input. Otherwise the output enable is high and received bits come from the separate input line.
- R10: Command codes 0, 3 and 7 are ignored. Status, select lines and the command register are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock |
| cs_o | output | NCS | Device select lines, level set per lane |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output driver enable for sdo |
| sdi | input | 1 | Serial data in, four-wire mode |
| sdio_in | input | 1 | Level seen on the shared data line, three-wire mode |

## Verification
The bench builds the engine with its default parameters: a 16-bit divider, four select lanes and 128-bit words. This makes every lane and the full 128-bit word span reachable. Dividers are drawn from 0 to 4. Because of that, even full-width words finish in a few hundred cycles, and dozens of random words can run across all four phase and polarity combinations, both wire modes, and lengths from 1 bit to 128 bits. The divider-0 case and the 1-bit and 128-bit length limits are also forced directly.

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int DIV_W = 16,
  parameter int NCS   = 4,
  parameter int MAXB  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sclk,
  output logic [NCS-1:0]   cs_o,
  output logic             sdo,
  output logic             sdo_en,
  input  logic             sdi,
  input  logic             sdio_in
);
  localparam int LW  = $clog2(MAXB);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int NDW = MAXB / 32;

  logic [31:0]      clkc_q, devc_q, cmd_q;
  logic [MAXB-1:0]  data_q, tx_q, rx_q, rx_nx, tx_ld;
  logic             busy_q, wc_q, act_q, rd_q, tp_q, do_q;
  logic [CSW-1:0]   sel_q, sel_nw;
  logic [LW:0]      left_q, wlen_nw;
  logic [DIV_W-1:0] cnt_q, divx;
  logic [DIV_W:0]   half;
  logic [2:0]       lane, code;
  logic             cmd_wr, go, inval, endp, capt, lead_pre, din, run, cpha_nw;

  assign divx     = (clkc_q[DIV_W-1:0] == '0) ? DIV_W'(1) : clkc_q[DIV_W-1:0];
  assign half     = ({1'b0, divx} + 1'b1) >> 1;
  assign lane     = devc_q[8*sel_q +: 3];
  assign code     = reg_wdata[18:16];
  assign cmd_wr   = reg_wr && reg_addr == 3'd2 && !busy_q;
  assign go       = cmd_wr && (code[1:0] == 2'b01 || code[1:0] == 2'b10);
  assign inval    = cmd_wr && code == 3'b100;
  assign sel_nw   = reg_wdata[28 +: CSW];
  assign cpha_nw  = devc_q[8*sel_nw + 2];
  assign wlen_nw  = {1'b0, reg_wdata[19 +: LW]} + 1'b1;
  assign tx_ld    = data_q << ((LW+1)'(MAXB) - wlen_nw);
  assign run      = busy_q && clkc_q[31];
  assign endp     = cnt_q == divx;
  assign lead_pre = {1'b0, cnt_q} == half - 1'b1;
  assign capt     = lane[2] ? endp : ({1'b0, cnt_q} == half);
  assign din      = tp_q ? sdio_in : sdi;
  assign rx_nx    = capt ? {rx_q[MAXB-2:0], din} : rx_q;

  assign sclk   = lane[0] ^ (run && ({1'b0, cnt_q} >= half));
  assign sdo    = do_q;
  assign sdo_en = !(busy_q && rd_q && tp_q);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (act_q && sel_q == CSW'(i)) ? devc_q[8*i+1] : !devc_q[8*i+1];
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = clkc_q;
      3'd1:    reg_rdata = devc_q;
      3'd2:    reg_rdata = cmd_q;
      3'd3:    reg_rdata = {30'b0, wc_q, busy_q};
      default: reg_rdata = data_q[32*reg_addr[1:0] +: 32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkc_q <= '0; devc_q <= '0; cmd_q <= '0; data_q <= '0;
      tx_q <= '0; rx_q <= '0; busy_q <= 1'b0; wc_q <= 1'b0; act_q <= 1'b0;
      rd_q <= 1'b0; tp_q <= 1'b0; do_q <= 1'b0; sel_q <= '0;
      left_q <= '0; cnt_q <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) clkc_q <= reg_wdata;
      if (reg_wr && reg_addr == 3'd1) devc_q <= reg_wdata;
      for (int i = 0; i < NDW; i++)
        if (reg_wr && reg_addr == 3'(4 + i)) data_q[32*i +: 32] <= reg_wdata;
      if (go || inval) begin
        cmd_q <= reg_wdata;
        wc_q  <= 1'b0;
      end
      if (inval) act_q <= 1'b0;
      if (go) begin
        act_q  <= 1'b1;
        sel_q  <= sel_nw;
        busy_q <= 1'b1;
        rd_q   <= code[0];
        tp_q   <= code[2];
        left_q <= wlen_nw;
        cnt_q  <= '0;
        rx_q   <= '0;
        if (!cpha_nw) begin
          do_q <= tx_ld[MAXB-1];
          tx_q <= tx_ld << 1;
        end else begin
          tx_q <= tx_ld;
        end
      end else if (run) begin
        cnt_q <= endp ? '0 : cnt_q + 1'b1;
        rx_q  <= rx_nx;
        if (lane[2] && lead_pre) begin
          do_q <= tx_q[MAXB-1];
          tx_q <= tx_q << 1;
        end
        if (endp) begin
          left_q <= left_q - 1'b1;
          if (left_q == (LW+1)'(1)) begin
            busy_q <= 1'b0;
            wc_q   <= 1'b1;
            if (rd_q) data_q <= rx_nx;
          end else if (!lane[2]) begin
            do_q <= tx_q[MAXB-1];
            tx_q <= tx_q << 1;
          end
        end
      end
    end
  end

  logic [NCS-1:0] cs_on;
  for (genvar i = 0; i < NCS; i++) begin : g_on
    assign cs_on[i] = cs_o[i] == devc_q[8*i+1];
  end

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_on));
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && busy_q) |=> $stable(cmd_q));
  p_done_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> wc_q);
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(busy_q && wc_q));
  p_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clkc_q[31]) |=> ($stable(left_q) && $stable(cnt_q)));
  p_drv_off_r9: assert property (@(posedge clk) disable iff (!rst_n) !sdo_en |-> busy_q);
endmodule

// File: tb/spi_word_engine_test.sv
module spi_word_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, sdo, sdo_en;
  logic [3:0] cs_o;
  logic sdi = 1'b0, sdio_in = 1'b1;

  spi_word_engine uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_o(cs_o), .sdo(sdo),
    .sdo_en(sdo_en), .sdi(sdi), .sdio_in(sdio_in));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, wd = 0, cyc = 0;
  logic [31:0] devc_b = '0;
  logic cpol_b = 0, cpha_b = 0, cspol_b = 0, tp_b = 0;
  int cs_b = 0, div_b = 1;
  logic [127:0] s_tx, s_rx;
  int samp = 0, last_lead = -1, per_meas = 0;
  logic prev_sclk = 0, prev_on = 0;

  task automatic drive(input logic b);
    sdi = tp_b ? ~b : b;
    sdio_in = ~sdi;
  endtask

  always @(negedge clk) begin
    logic on, raw, praw;
    cyc++;
    on = (cs_o[cs_b] == cspol_b);
    raw = sclk ^ cpol_b;
    praw = prev_sclk ^ cpol_b;
    if (on && prev_on) begin
      if (raw && !praw) begin
        if (last_lead >= 0) per_meas = cyc - last_lead;
        last_lead = cyc;
        if (!cpha_b) begin s_rx = {s_rx[126:0], sdo}; samp++; end
        else begin drive(s_tx[127]); s_tx = s_tx << 1; end
      end else if (!raw && praw) begin
        if (cpha_b) begin s_rx = {s_rx[126:0], sdo}; samp++; end
        else begin s_tx = s_tx << 1; drive(s_tx[127]); end
      end
    end
    prev_sclk = sclk;
    prev_on = on;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd128(output logic [127:0] v);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rdr(3'(4 + i), w);
      v[32*i +: 32] = w;
    end
  endtask

  function automatic logic [127:0] msk(input int wl);
    return (wl >= 128) ? '1 : ((128'b1 << wl) - 1);
  endfunction

  task automatic setmode(input int div, input bit en, input logic [31:0] devc, input int cs);
    wr(3'd0, {en, 15'b0, 16'(div)});
    wr(3'd1, devc);
    devc_b = devc; div_b = (div == 0) ? 1 : div;
    cs_b = cs;
    cpol_b = devc[8*cs]; cspol_b = devc[8*cs+1]; cpha_b = devc[8*cs+2];
  endtask

  task automatic start_word(input int cs, input int wl, input bit rd, input bit tp,
                            input logic [127:0] dat, input logic [127:0] resp,
                            output logic [31:0] cmd);
    logic [31:0] st;
    tp_b = tp;
    s_tx = resp << (128 - wl);
    s_rx = '0; samp = 0; last_lead = -1; per_meas = 0;
    drive(s_tx[127]);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), dat[32*i +: 32]);
    cmd = (32'(cs) << 28) | (32'(wl - 1) << 19) | (32'((rd ? 1 : 2) | (tp ? 4 : 0)) << 16)
          | 32'($urandom_range(0, 4095));
    wr(3'd2, cmd);
    rdr(3'd3, st);
    chk(st == 32'd1, "R5 busy set after accept", st, 1);
    chk(sdo_en == !(rd && tp), "R9 driver enable during word", sdo_en, !(rd && tp));
  endtask

  task automatic finish_word(input int cs, input int wl, input bit rd,
                             input logic [127:0] dat, input logic [127:0] resp, input logic [31:0] cmd);
    logic [31:0] st, cr;
    logic [127:0] got;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      rdr(3'd3, st);
      n++;
    end while (st[1:0] != 2'b10 && n < 5000);
    repeat (2) @(negedge clk);
    chk(st[1:0] == 2'b10, "R5 complete set, busy clear", st, 2);
    chk(samp == wl, "R6/R7 bit count of word", samp, wl);
    rd128(got);
    if (rd) chk(got == (resp & msk(wl)), "R8 received word", got, resp & msk(wl));
    else begin
      chk((s_rx & msk(wl)) == (dat & msk(wl)), "R7 sent word", s_rx & msk(wl), dat & msk(wl));
      chk(got == dat, "R7 data kept", got, dat);
    end
    if (wl >= 2) chk(per_meas == div_b + 1, "R1 sclk period", per_meas, div_b + 1);
    chk(sclk == cpol_b, "R2 sclk idle level", sclk, cpol_b);
    chk(sdo_en == 1'b1, "R9 driver on when idle", sdo_en, 1);
    rdr(3'd2, cr);
    chk(cr == cmd, "R3 command readback", cr, cmd);
    for (int j = 0; j < 4; j++) begin
      logic e;
      e = (j == cs) ? devc_b[8*j+1] : ~devc_b[8*j+1];
      chk(cs_o[j] == e, "R4 select held after word", cs_o[j], e);
    end
  endtask

  task automatic end_frame();
    logic [31:0] st;
    wr(3'd2, 32'h0004_0000);
    rdr(3'd3, st);
    chk(st == 0, "R5 invalidate clears complete", st, 0);
    for (int j = 0; j < 4; j++)
      chk(cs_o[j] == ~devc_b[8*j+1], "R4 select released by code 4", cs_o[j], ~devc_b[8*j+1]);
  endtask

  task automatic word(input int cs, input int wl, input bit rd, input bit tp);
    logic [127:0] dat, resp;
    logic [31:0] cmd;
    dat = {$urandom, $urandom, $urandom, $urandom};
    resp = {$urandom, $urandom, $urandom, $urandom};
    start_word(cs, wl, rd, tp, dat, resp, cmd);
    finish_word(cs, wl, rd, dat, resp, cmd);
  endtask

  initial begin
    logic [31:0] st, v, cmd_a, cmd_b;
    logic [127:0] dat;
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rdr(3'd3, st);
    chk(st == 0, "R5 reset status", st, 0);
    rdr(3'd2, v);
    chk(v == 0, "R3 reset command", v, 0);
    chk(cs_o == 4'hf, "R4 reset selects inactive", cs_o, 4'hf);
    chk(sclk == 0 && sdo_en == 1, "R1 reset sclk idle, driver on", {sclk, sdo_en}, 2'b01);

    setmode(0, 1, 32'h0000_0000, 0);
    word(0, 1, 0, 0);
    end_frame();
    setmode(1, 1, 32'h0007_0000, 2);
    word(2, 128, 1, 0);
    word(2, 128, 0, 0);
    end_frame();
    setmode(3, 1, 32'h0500_0000, 3);
    word(3, 128, 1, 1);
    end_frame();

    setmode(3, 1, 32'h0000_0200, 1);
    dat = {$urandom, $urandom, $urandom, $urandom};
    start_word(1, 20, 0, 0, dat, '0, cmd_a);
    cmd_b = (32'd3 << 28) | (32'd4 << 19) | (32'd1 << 16);
    wr(3'd2, cmd_b);
    finish_word(1, 20, 0, dat, '0, cmd_a);
    chk(cs_o[3] == 1'b1, "R6 busy command no select", cs_o[3], 1);
    wr(3'd2, (32'd3 << 28) | (32'd7 << 16));
    rdr(3'd3, st);
    chk(st == 32'd2, "R10 code 7 ignored status", st, 2);
    rdr(3'd2, v);
    chk(v == cmd_a, "R10 code 7 ignored command", v, cmd_a);
    wr(3'd2, (32'd2 << 28) | (32'd3 << 16));
    rdr(3'd3, st);
    chk(st == 32'd2, "R10 code 3 ignored status", st, 2);
    chk(cs_o[1] == 1'b1 && cs_o[2] == 1'b1, "R10 ignored code keeps select", cs_o, 4'b1111);
    end_frame();

    setmode(2, 0, 32'h0000_0004, 0);
    dat = {$urandom, $urandom, $urandom, $urandom};
    start_word(0, 9, 0, 0, dat, '0, cmd_a);
    repeat (40) @(negedge clk);
    rdr(3'd3, st);
    chk(st == 32'd1 && samp == 0, "R1 disabled clock holds word", {st, samp}, 1);
    chk(sclk == cpol_b, "R1 sclk idle while disabled", sclk, cpol_b);
    wr(3'd0, 32'h8000_0002);
    finish_word(0, 9, 0, dat, '0, cmd_a);
    end_frame();

    for (int it = 0; it < 40; it++) begin
      int cs, wl;
      cs = $urandom_range(0, 3);
      case ($urandom_range(0, 3))
        0: wl = 1;
        1: wl = 128;
        default: wl = $urandom_range(1, 128);
      endcase
      setmode($urandom_range(0, 4), 1, $urandom, cs);
      word(cs, wl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 1) == 1) word(cs, $urandom_range(1, 40), 1, 0);
      end_frame();
    end

    summary();
    $finish;
  end
endmodule